// File: doc/BRIEF.md
# Triggered Amplitude Profile Sequencer

This block plays back a stored list of amplitude records and produces two amplitude words, one for an X channel and one for a Y channel, which a downstream gain stage turns into drive levels. Each record names the channels it affects, and then either sets a level at once or moves the level in a straight line toward a target at a programmed step size. Curved envelopes are built by chaining several straight segments. The list lives in an external record memory. The block reads that memory through a synchronous read port with one cycle of latency.

An external trigger starts playback at the first record. In a record that waits, the trigger moves playback to the next record. When the last valid record has finished, both amplitudes keep their final values. From that point the next event decides what happens. A trigger replays the list from the start. A disable turns both channels off. A host clear returns the block to its reset state. The trigger and disable pins are asynchronous, so each passes through a two-flop synchroniser. The trigger acts only on its rising edge.

Top module: `amp_seq`

## Requirements
- R1: After reset, and until the first trigger, both `amp_x` and `amp_y` are 0 and `rd_addr` is 0.
- R2: Only a rising edge on `trig_in` counts as a trigger. A trigger level held high for many cycles acts as a single trigger.
- R3: A record word holds four fields: `[1:0]` channel select (bit 0 selects X, bit 1 selects Y), `[3:2]` mode, `[13:4]` rate and `[25:14]` target. A channel whose select bit is 0 keeps its value for the whole record.
- R4: Mode 0 (step) loads the target into the selected channels. Playback then moves to the next record without waiting for a trigger.
- R5: Mode 1 (hold) loads the target into the selected channels. Both outputs then stay fixed until a trigger moves playback to the next record.
- R6: Mode 2 (ramp up) adds the rate to each selected channel, and mode 3 (ramp down) subtracts it. Each change happens on a tick of a prescaler that fires once every `tick_div`+1 cycles.
- R7: A ramp step never passes the target: it saturates at the target value. A rate of 0 jumps straight to the target. The ramp record ends on the tick where every selected channel equals the target.
- R8: Triggers that arrive while a ramp is running are ignored.
- R9: After record `rec_count`-1 has finished, both outputs keep their final values. The next trigger restarts playback from record 0.
- R10: While the synchronised `dis_in` is high, both outputs are 0 and playback is abandoned. Triggers have no effect during that time. After `dis_in` is released, a trigger restarts playback from record 0.
- R11: A one-cycle `host_clr` sets both outputs and `rd_addr` to 0 and returns the block to idle.
- R12: When `rec_count` is 0, a trigger has no effect and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clr | input | 1 | Synchronous clear from the host side |
| trig_in | input | 1 | Asynchronous trigger pin |
| dis_in | input | 1 | Asynchronous disable pin |
| rec_count | input | IW (10) | Number of valid records |
| tick_div | input | PW (16) | Ramp prescaler divide value minus one |
| rd_addr | output | IW (10) | Record memory read address |
| rd_data | input | AW+RW+4 (26) | Record word, valid one cycle after the address |
| amp_x | output | AW (12) | X channel amplitude word |
| amp_y | output | AW (12) | Y channel amplitude word |

## Verification
The bench compares every change of the two outputs against a queue of expected pairs. For steps inside a ramp it also checks the gap between changes, so a prescaler that is off by one shows up as a wrong gap. Ramps are chosen so that one of them lands exactly on its target and another must saturate. A design that overshoots would therefore produce a value past 20, and one that fails to end the record would stall. Other cases are a trigger held high across a hold record, a trigger during a ramp, a trigger while disabled and a trigger with an empty list. A design that advanced twice, or acted on a trigger it should ignore, would produce an output change that the queue does not expect. Replay after the end of the list and a record that selects only X catch an index that fails to wrap to 0 and a write to a channel that was not selected.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOAD  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_RAMP  = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        MD_STEP = 2'd0,
        MD_HOLD = 2'd1,
        MD_UP   = 2'd2,
        MD_DOWN = 2'd3
    } rec_mode_t;

    localparam int unsigned SEL_X = 0;
    localparam int unsigned SEL_Y = 1;

endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2

endmodule

// File: rtl/amp_tick.sv
module amp_tick #(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/amp_seq.sv
module amp_seq
    import amp_seq_pkg::*;
#(
    parameter int unsigned AW     = 12,
    parameter int unsigned RW     = 10,
    parameter int unsigned IW     = 10,
    parameter int unsigned PW     = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_clr,
    input  logic                 trig_in,
    input  logic                 dis_in,
    input  logic [IW-1:0]        rec_count,
    input  logic [PW-1:0]        tick_div,
    output logic [IW-1:0]        rd_addr,
    input  logic [AW+RW+3:0]     rd_data,
    output logic [AW-1:0]        amp_x,
    output logic [AW-1:0]        amp_y
);
    localparam int unsigned RATE_LSB = 4;
    localparam int unsigned TGT_LSB  = RATE_LSB + RW;

    typedef struct packed {
        seq_state_t    st;
        logic [IW-1:0] idx;
        logic [AW-1:0] ax;
        logic [AW-1:0] ay;
        logic [1:0]    sel;
        logic          down;
        logic [RW-1:0] rate;
        logic [AW-1:0] tgt;
    } seq_regs_t;

    seq_regs_t q, d;

    logic trig_pulse, dis_lvl, dis_unused_rise, trig_unused_lvl, tick;

    amp_sync #(.STAGES(STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .pin(trig_in),
        .level(trig_unused_lvl), .rise(trig_pulse)
    );

    amp_sync #(.STAGES(STAGES)) u_dis_sync (
        .clk(clk), .rst_n(rst_n), .pin(dis_in),
        .level(dis_lvl), .rise(dis_unused_rise)
    );

    amp_tick #(.PW(PW)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(q.st == ST_RAMP),
        .div(tick_div), .tick(tick)
    );

    // record fields
    logic [1:0]    f_sel;
    rec_mode_t     f_mode;
    logic [RW-1:0] f_rate;
    logic [AW-1:0] f_tgt;

    assign f_sel  = rd_data[1:0];
    assign f_mode = rec_mode_t'(rd_data[3:2]);
    assign f_rate = rd_data[TGT_LSB-1:RATE_LSB];
    assign f_tgt  = rd_data[TGT_LSB+AW-1:TGT_LSB];

    function automatic logic [AW-1:0] ramp_step(
        input logic [AW-1:0] cur,
        input logic [AW-1:0] tgt,
        input logic [RW-1:0] rate,
        input logic          down
    );
        logic [AW:0] r_ext, c_ext, t_ext, sum;
        r_ext = (AW+1)'(rate);
        c_ext = {1'b0, cur};
        t_ext = {1'b0, tgt};
        sum   = c_ext + r_ext;
        if (rate == '0)               return tgt;
        else if (!down && sum >= t_ext) return tgt;
        else if (!down)                 return sum[AW-1:0];
        else if (c_ext < t_ext + r_ext) return tgt;
        else                            return cur - AW'(rate);
    endfunction

    logic          is_last;
    logic [AW-1:0] nx, ny;

    always_comb begin
        is_last = ((IW+1)'(q.idx) + (IW+1)'(1)) >= (IW+1)'(rec_count);
        nx = q.sel[SEL_X] ? ramp_step(q.ax, q.tgt, q.rate, q.down) : q.ax;
        ny = q.sel[SEL_Y] ? ramp_step(q.ay, q.tgt, q.rate, q.down) : q.ay;

        d = q;
        unique case (q.st)
            ST_IDLE, ST_DONE: begin
                if (trig_pulse && rec_count != '0) begin
                    d.idx = '0;
                    d.st  = ST_FETCH;
                end
            end
            ST_FETCH: d.st = ST_LOAD;
            ST_LOAD: begin
                d.sel  = f_sel;
                d.rate = f_rate;
                d.tgt  = f_tgt;
                d.down = (f_mode == MD_DOWN);
                if (f_mode == MD_STEP || f_mode == MD_HOLD) begin
                    if (f_sel[SEL_X]) d.ax = f_tgt;
                    if (f_sel[SEL_Y]) d.ay = f_tgt;
                end
                if (f_mode == MD_HOLD) d.st = ST_HOLD;
                else if (f_mode == MD_STEP) begin
                    if (is_last) d.st = ST_DONE;
                    else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = ST_FETCH;
                    end
                end else d.st = ST_RAMP;
            end
            ST_HOLD: begin
                if (trig_pulse) begin
                    if (is_last) d.st = ST_DONE;
                    else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = ST_FETCH;
                    end
                end
            end
            ST_RAMP: begin
                if (tick) begin
                    d.ax = nx;
                    d.ay = ny;
                    if ((!q.sel[SEL_X] || nx == q.tgt) &&
                        (!q.sel[SEL_Y] || ny == q.tgt)) begin
                        if (is_last) d.st = ST_DONE;
                        else begin
                            d.idx = q.idx + 1'b1;
                            d.st  = ST_FETCH;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (dis_lvl || host_clr) begin
            d.st  = ST_IDLE;
            d.idx = '0;
            d.ax  = '0;
            d.ay  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.idx;
    assign amp_x   = q.ax;
    assign amp_y   = q.ay;

    AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dis_lvl |=> (amp_x == '0 && amp_y == '0)); // R10

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_clr |=> (amp_x == '0 && amp_y == '0 && rd_addr == '0)); // R11

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && !dis_lvl && !host_clr) |=> ($stable(amp_x) && $stable(amp_y))); // R5

    AST_RAMP_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RAMP && !q.down && q.sel[SEL_X] && amp_x <= q.tgt && !dis_lvl && !host_clr)
        |=> (amp_x <= $past(q.tgt))); // R7

    AST_ADDR_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH || q.st == ST_LOAD) |-> (rd_addr < rec_count)); // R9

endmodule

// File: tb/amp_seq_tb.sv
module amp_seq_tb;
    localparam int CLK_P = 10;
    localparam int AW = 12;
    localparam int RW = 10;
    localparam int IW = 10;
    localparam int PW = 16;
    localparam int REC_W = AW + RW + 4;
    localparam int GAP = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic host_clr = 0, trig_in = 0, dis_in = 0;
    logic [IW-1:0] rec_count = '0;
    logic [PW-1:0] tick_div = PW'(GAP - 1);
    logic [IW-1:0] rd_addr;
    logic [REC_W-1:0] rd_data = '0;
    logic [AW-1:0] amp_x, amp_y;

    logic [REC_W-1:0] mem [0:7];

    always #(CLK_P/2) clk = ~clk;

    always_ff @(posedge clk) rd_data <= mem[rd_addr[2:0]];

    amp_seq u_dut (
        .clk(clk), .rst_n(rst_n), .host_clr(host_clr), .trig_in(trig_in),
        .dis_in(dis_in), .rec_count(rec_count), .tick_div(tick_div),
        .rd_addr(rd_addr), .rd_data(rd_data), .amp_x(amp_x), .amp_y(amp_y)
    );

    typedef struct {
        int    x;
        int    y;
        int    gap;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    n_chk = 0, n_fail = 0;
    int    cyc = 0, last_chg = 0;
    int    px = 0, py = 0;
    string cur_req = "R1";
    bit    finished = 0;

    function automatic logic [REC_W-1:0] mk(int sel, int mode, int rate, int tgt);
        return {AW'(tgt), RW'(rate), 2'(mode), 2'(sel)};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(int x, int y, int gap, string req);
        exp_t e;
        e.x = x; e.y = y; e.gap = gap; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: compare every output change with the queue
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (int'(amp_x) != px || int'(amp_y) != py) begin
                if (sb.size() == 0) begin
                    check(0, cur_req, "unexpected change x", int'(amp_x), px);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(amp_x) == e.x, e.req, "amp_x", int'(amp_x), e.x);
                    check(int'(amp_y) == e.y, e.req, "amp_y", int'(amp_y), e.y);
                    if (e.gap >= 0)
                        check(cyc - last_chg == e.gap, e.req, "step gap", cyc - last_chg, e.gap);
                end
                last_chg = cyc;
                px = int'(amp_x);
                py = int'(amp_y);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1;
        wait_cyc(3);
        trig_in = 0;
        wait_cyc(3);
    endtask

    task automatic drain(string req);
        int t = 0;
        while (sb.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(sb.size() == 0, req, "pending expected items", sb.size(), 0);
        sb.delete();
        wait_cyc(20);
    endtask

    task automatic push_prog_a_first();
        push(100, 100, -1, "R4");
        push(110, 100, -1, "R6");
        push(120, 100, GAP, "R6");
        push(130, 100, GAP, "R7");
        push(130, 50, -1, "R5");
    endtask

    initial begin
        wait_cyc(100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = '0;
        wait_cyc(5);
        rst_n = 1;
        wait_cyc(2);
        check(amp_x == 0, "R1", "amp_x after reset", int'(amp_x), 0);
        check(amp_y == 0, "R1", "amp_y after reset", int'(amp_y), 0);
        check(rd_addr == 0, "R1", "rd_addr after reset", int'(rd_addr), 0);

        // list A: step both, ramp X up, hold Y, ramp both down
        mem[0] = mk(3, 0, 0, 100);
        mem[1] = mk(1, 2, 10, 130);
        mem[2] = mk(2, 1, 0, 50);
        mem[3] = mk(3, 3, 15, 20);
        rec_count = 4;
        wait_cyc(20);
        check(amp_x == 0 && amp_y == 0, "R1", "no trigger yet", int'(amp_x), 0);

        cur_req = "R8";
        push_prog_a_first();
        pulse_trig();
        begin
            int t = 0;
            while (amp_x != 110 && t < 500) begin @(negedge clk); t++; end
        end
        pulse_trig();  // R8: must be ignored in the ramp
        drain("R8");
        check(amp_x == 130 && amp_y == 50, "R5", "held after hold record", int'(amp_y), 50);

        cur_req = "R7";
        push(115, 35, -1, "R6");
        push(100, 20, GAP, "R6");
        push(85, 20, GAP, "R6");
        push(70, 20, GAP, "R6");
        push(55, 20, GAP, "R6");
        push(40, 20, GAP, "R6");
        push(25, 20, GAP, "R6");
        push(20, 20, GAP, "R7");
        pulse_trig();
        drain("R7");
        check(amp_x == 20 && amp_y == 20, "R9", "final values kept", int'(amp_x), 20);

        cur_req = "R9";
        push_prog_a_first();
        pulse_trig();
        drain("R9");

        cur_req = "R10";
        push(0, 0, -1, "R10");
        dis_in = 1;
        drain("R10");
        pulse_trig();
        wait_cyc(20);
        check(amp_x == 0 && amp_y == 0, "R10", "trigger while disabled", int'(amp_x), 0);
        dis_in = 0;
        wait_cyc(10);
        push(100, 100, -1, "R10");
        push(110, 100, -1, "R10");
        push(120, 100, GAP, "R10");
        push(130, 100, GAP, "R10");
        push(130, 50, -1, "R10");
        pulse_trig();
        drain("R10");

        cur_req = "R11";
        push(0, 0, -1, "R11");
        @(negedge clk); host_clr = 1;
        @(negedge clk); host_clr = 0;
        drain("R11");
        check(rd_addr == 0, "R11", "rd_addr after clear", int'(rd_addr), 0);

        // list B: rate 0 jumps, ramp up from above target saturates
        cur_req = "R7";
        mem[0] = mk(3, 0, 0, 200 - 193 + 193);
        mem[0] = mk(1, 0, 0, 200);
        mem[1] = mk(3, 2, 0, 150);
        rec_count = 2;
        push(200, 0, -1, "R4");
        push(150, 150, -1, "R7");
        pulse_trig();
        drain("R7");

        // list C: held trigger level acts once; X-only record leaves Y
        cur_req = "R2";
        mem[0] = mk(3, 1, 0, 60);
        mem[1] = mk(1, 0, 0, 61);
        push(60, 60, -1, "R2");
        @(negedge clk); trig_in = 1;
        wait_cyc(40);
        drain("R2");
        trig_in = 0;
        wait_cyc(10);
        check(amp_x == 60 && amp_y == 60, "R2", "held level advanced", int'(amp_x), 60);
        cur_req = "R3";
        push(61, 60, -1, "R3");
        pulse_trig();
        drain("R3");
        check(amp_y == 60, "R3", "unselected Y kept", int'(amp_y), 60);

        // empty list: trigger does nothing
        cur_req = "R12";
        rec_count = 0;
        wait_cyc(2);
        pulse_trig();
        wait_cyc(30);
        check(amp_x == 61 && amp_y == 60, "R12", "empty list trigger", int'(amp_x), 61);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule